// File: doc/BRIEF.md
# I2C Master Clock Pacer with Stretch Tolerance

This block produces the SCL waveform for the master side of an I2C bus. A request names how many clock pulses are wanted, typically nine for a byte plus acknowledge. For each pulse the block first pulls SCL low for a timed interval, then lets it go, then times a high interval. At the end of the high interval it pulls SCL low again and strobes `phase_tick` so that a separate data shifter can move SDA. After the last pulse SCL stays low and `done` pulses once.

Timing comes from a 7-bit reloadable down-counter. The counter advances once per machine cycle, which is `CLKS_PER_MC` system clocks (default 4). A slave device may stretch the clock by holding SCL low after the master has let go. While that happens the counter is frozen. It reloads and starts timing the high interval only on the machine cycle in which the synchronized SCL is actually seen high. A full high interval therefore follows every stretch, however long it lasts. The SCL line passes through a two-flop synchronizer before it is used.

Top module: `i2c_scl_pacer`

## Requirements
- R1: Whenever the active-low reset is asserted, including during a transfer, `scl_drive_low`, `phase_tick` and `done` are 0, and the transfer in progress is dropped.
- R2: Each low phase drives SCL low for exactly CLKS_PER_MC*(reload+1) clocks. This is 4*(reload+1) with the defaults.
- R3: After release, the counter holds its value while synchronized SCL is low. High timing starts on the first machine cycle that sees SCL high. The time SCL is actually high before the master pulls it low again therefore lies between 4*(reload+1)+3 and 4*(reload+1)+6 clocks, for any stretch length.
- R4: With no stretching, each released interval lasts exactly 4*(reload+2) clocks: one machine cycle for the sampling step plus reload+1 counted machine cycles.
- R5: `phase_tick` is a one-clock pulse. It is issued only in the clock in which SCL is pulled low at the end of a high interval, and once per pulse.
- R6: A request of N pulses (1..15 on `req_pulses`) produces exactly N released intervals. `done` is high for exactly one clock, in the same clock as the last `phase_tick`, and SCL then stays driven low.
- R7: A request with `req_pulses` = 0 raises `done` in the clock after `start` is sampled. It issues no `phase_tick` and leaves `scl_drive_low` unchanged.
- R8: `start` is ignored while a transfer is in progress. The pulse count of the running transfer is unaffected.
- R9: With `enable` low, SCL is released by the next clock, any transfer is dropped without `done`, and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases SCL and aborts |
| reload | input | 7 | Counter reload value setting each phase length |
| scl_in | input | 1 | Level of the SCL line as seen at the pin |
| start | input | 1 | Request strobe, taken only when idle |
| req_pulses | input | 4 | Number of SCL pulses to generate |
| scl_drive_low | output | 1 | Open-drain control: 1 pulls SCL low, 0 releases it |
| phase_tick | output | 1 | Strobe at each SCL falling edge made by the block |
| done | output | 1 | One-clock flag after the last requested pulse |

## Verification
The hardest case to reach is a stretch that ends at every possible offset from the machine-cycle boundary. Only then are the synchronizer latency and the once-per-machine-cycle sampling exercised together at their extremes.

The bench models the bus as a wired-AND of the block's drive and a slave model. In the slave model, on each pulse a random draw decides whether to keep SCL low after release, and for a random number of clocks (0 to 39). This spreads the moment SCL rises over all four phase offsets. Each measured high time is checked against the bound window, and each unstretched interval against the exact length. Directed runs cover the longest reload, a start request made mid-transfer, a drop of enable, and a reset during a transfer.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Machine cycles counted in one timed phase for a given reload value.
  function automatic int mc_per_phase(input int reload_val);
    return reload_val + 1;
  endfunction

  // True when the pulse about to finish is the final one of the request.
  function automatic bit is_final_pulse(input int remaining);
    return remaining == 1;
  endfunction

  // Width of a counter that must hold values 0..limit-1 (at least 1 bit).
  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/scl_pacer_mcdiv.sv
module scl_pacer_mcdiv #(
  parameter int CLKS_PER_MC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic mc_tick
);
  import scl_pacer_pkg::*;

  localparam int PW = cnt_width(CLKS_PER_MC);
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MC - 1);

  logic [PW-1:0] div_q;

  assign mc_tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clear || mc_tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/scl_pacer_sync.sv
module scl_pacer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  // Bus idles high, so every stage resets to 1.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b1;
        else        stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/scl_pacer_brg.sv
module scl_pacer_brg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

endmodule

// File: rtl/scl_pacer_seq.sv
module scl_pacer_seq
  import scl_pacer_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [CNT_W-1:0] req_pulses,
  input  logic             mc_tick,
  input  logic             scl_high,
  input  logic             brg_zero,
  output logic             brg_load,
  output logic             brg_dec,
  output logic             div_clear,
  output logic             drive_low,
  output logic             phase_tick,
  output logic             done,
  output phase_e           phase
);

  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] remain_q, remain_n;
  logic             drive_q, drive_n;
  logic             tick_q, tick_n;
  logic             done_q, done_n;

  always_comb begin
    phase_n   = phase_q;
    remain_n  = remain_q;
    drive_n   = drive_q;
    tick_n    = 1'b0;
    done_n    = 1'b0;
    brg_load  = 1'b0;
    brg_dec   = 1'b0;
    div_clear = 1'b0;
    if (!enable) begin
      phase_n   = PH_IDLE;
      drive_n   = 1'b0;
      div_clear = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            if (req_pulses == '0) begin
              done_n = 1'b1;
            end else begin
              phase_n   = PH_LOW;
              remain_n  = req_pulses;
              drive_n   = 1'b1;
              brg_load  = 1'b1;
              div_clear = 1'b1;
            end
          end
        end
        PH_LOW: begin
          if (mc_tick) begin
            if (brg_zero) begin
              phase_n = PH_WAIT;
              drive_n = 1'b0;
            end else begin
              brg_dec = 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (mc_tick && scl_high) begin
            phase_n  = PH_HIGH;
            brg_load = 1'b1;
          end
        end
        PH_HIGH: begin
          if (mc_tick) begin
            if (brg_zero) begin
              tick_n   = 1'b1;
              drive_n  = 1'b1;
              remain_n = remain_q - 1'b1;
              if (is_final_pulse(int'(remain_q))) begin
                phase_n = PH_IDLE;
                done_n  = 1'b1;
              end else begin
                phase_n  = PH_LOW;
                brg_load = 1'b1;
              end
            end else begin
              brg_dec = 1'b1;
            end
          end
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      remain_q <= '0;
      drive_q  <= 1'b0;
      tick_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      remain_q <= remain_n;
      drive_q  <= drive_n;
      tick_q   <= tick_n;
      done_q   <= done_n;
    end
  end

  assign drive_low  = drive_q;
  assign phase_tick = tick_q;
  assign done       = done_q;
  assign phase      = phase_q;

endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int CNT_W       = 4,
  parameter int CLKS_PER_MC = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                scl_in,
  input  logic                start,
  input  logic [CNT_W-1:0]    req_pulses,
  output logic                scl_drive_low,
  output logic                phase_tick,
  output logic                done
);

  // Named internal events, visible to the bound checker.
  logic                mc_tick;
  logic                scl_sync;
  logic                brg_load;
  logic                brg_dec;
  logic                brg_zero;
  logic [RELOAD_W-1:0] brg_cnt;
  logic                div_clear;
  phase_e              phase;

  scl_pacer_mcdiv #(.CLKS_PER_MC(CLKS_PER_MC)) mcdiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (div_clear),
    .mc_tick (mc_tick)
  );

  scl_pacer_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (scl_in),
    .dout  (scl_sync)
  );

  scl_pacer_brg #(.W(RELOAD_W)) brg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (brg_load),
    .load_val (reload),
    .dec      (brg_dec),
    .count    (brg_cnt),
    .zero     (brg_zero)
  );

  scl_pacer_seq #(.CNT_W(CNT_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start      (start),
    .req_pulses (req_pulses),
    .mc_tick    (mc_tick),
    .scl_high   (scl_sync),
    .brg_zero   (brg_zero),
    .brg_load   (brg_load),
    .brg_dec    (brg_dec),
    .div_clear  (div_clear),
    .drive_low  (scl_drive_low),
    .phase_tick (phase_tick),
    .done       (done),
    .phase      (phase)
  );

endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk
  import scl_pacer_pkg::*;
#(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         mc_tick,
  input logic         scl_sync,
  input logic         brg_zero,
  input logic [W-1:0] brg_cnt,
  input phase_e       phase,
  input logic         drive_low,
  input logic         phase_tick,
  input logic         done
);

  // R3
  wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !(mc_tick && scl_sync)) |=> $stable(brg_cnt));

  // R3
  wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |-> !drive_low);

  // R5
  tick_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> drive_low);

  // R5
  tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> $past(mc_tick && brg_zero && phase == PH_HIGH));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drive_low && !done && !phase_tick));

endmodule

bind i2c_scl_pacer scl_pacer_chk #(.W(RELOAD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .mc_tick    (mc_tick),
  .scl_sync   (scl_sync),
  .brg_zero   (brg_zero),
  .brg_cnt    (brg_cnt),
  .phase      (phase),
  .drive_low  (scl_drive_low),
  .phase_tick (phase_tick),
  .done       (done)
);

// File: tb/i2c_scl_pacer_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_pacer_tb_top;

  localparam int RW = 7;
  localparam int CW = 4;
  localparam int MC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [RW-1:0] reload = '0;
  logic          start = 1'b0;
  logic [CW-1:0] req_pulses = '0;
  logic          scl_in;
  logic          scl_drive_low, phase_tick, done;
  logic          stretch;
  bit            st_mode = 1'b0;
  int unsigned   st_left;
  int            total = 0;
  int            bad = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  // Wired-AND bus: released line is high unless the slave model holds it.
  assign scl_in = ~scl_drive_low & ~stretch;

  i2c_scl_pacer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .reload        (reload),
    .scl_in        (scl_in),
    .start         (start),
    .req_pulses    (req_pulses),
    .scl_drive_low (scl_drive_low),
    .phase_tick    (phase_tick),
    .done          (done)
  );

  // Slave model: while the master drives low, decide whether to keep holding
  // after release, and for how many clocks.
  always @(posedge clk) begin
    if (!rst_n) begin
      stretch <= 1'b0;
      st_left <= 0;
    end else if (scl_drive_low) begin
      stretch <= st_mode && ($urandom % 2 == 1);
      st_left <= $urandom % 40;
    end else if (st_left != 0) begin
      st_left <= st_left - 1;
    end else begin
      stretch <= 1'b0;
    end
  end

  function automatic int exp_low(input int r);  return MC * (r + 1); endfunction
  function automatic int exp_rel(input int r);  return MC * ((r + 1) + 1); endfunction
  function automatic int high_min(input int r); return MC * (r + 1) + 3; endfunction
  function automatic int high_max(input int r); return MC * (r + 1) + 6; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Runs one request and measures every phase at the falling clock edge.
  task automatic do_xfer(input int r, input int n, input bit mid_start);
    int  low_len, rel_len, high_len, pulses, ticks, dones, guard;
    bit  in_rel, stretched;
    @(negedge clk);
    reload = RW'(r); req_pulses = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    low_len = 0; rel_len = 0; high_len = 0; pulses = 0; ticks = 0; dones = 0;
    guard = 0; in_rel = 1'b0; stretched = 1'b0;
    while (dones == 0 && guard < 60000) begin
      if (phase_tick) ticks++;
      if (done) dones++;
      if (!in_rel) begin
        if (scl_drive_low) low_len++;
        else begin
          chk(low_len == exp_low(r), "R2 low length", low_len, exp_low(r));
          in_rel = 1'b1; rel_len = 1; high_len = scl_in ? 1 : 0; stretched = !scl_in;
        end
      end else begin
        if (!scl_drive_low) begin
          rel_len++;
          if (scl_in) high_len++;
        end else begin
          pulses++;
          chk(high_len >= high_min(r) && high_len <= high_max(r),
              "R3 high time after release", high_len, high_min(r));
          if (!stretched)
            chk(rel_len == exp_rel(r), "R4 unstretched release", rel_len, exp_rel(r));
          chk(phase_tick == 1'b1, "R5 tick at falling edge", int'(phase_tick), 1);
          in_rel = 1'b0; low_len = 1;
        end
      end
      if (mid_start && guard == 10) begin
        req_pulses = CW'(n + 3); start = 1'b1;   // R8: must be ignored
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(pulses == n, "R6 pulse count", pulses, n);
    chk(ticks == n, "R5 tick count", ticks, n);
    chk(dones == 1, "R6 done seen once", dones, 1);
    chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
    repeat (6) @(negedge clk);
    chk(scl_drive_low == 1'b1, "R6 SCL held low after done", int'(scl_drive_low), 1);
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit dl0;
    int r, n;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(scl_drive_low == 1'b0, "R1 reset drive", int'(scl_drive_low), 0);
    chk(phase_tick == 1'b0, "R1 reset tick", int'(phase_tick), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1; enable = 1'b1;
    repeat (3) @(negedge clk);

    // Directed corners
    st_mode = 1'b0;
    do_xfer(0, 1, 1'b0);
    do_xfer(5, 9, 1'b0);
    do_xfer(127, 2, 1'b0);
    st_mode = 1'b1;
    do_xfer(0, 15, 1'b0);
    do_xfer(3, 9, 1'b0);
    // R8: start during transfer
    st_mode = 1'b0;
    do_xfer(2, 4, 1'b1);

    // R7: zero-pulse request
    @(negedge clk);
    dl0 = scl_drive_low; req_pulses = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R7 done on zero request", int'(done), 1);
    chk(scl_drive_low == dl0, "R7 SCL unchanged", int'(scl_drive_low), int'(dl0));
    chk(phase_tick == 1'b0, "R7 no tick", int'(phase_tick), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single", int'(done), 0);

    // Random transfers with random stretching
    for (int i = 0; i < 12; i++) begin
      r = $urandom % 16;
      n = 1 + ($urandom % 15);
      st_mode = ($urandom % 3) != 0;
      do_xfer(r, n, 1'b0);
    end
    st_mode = 1'b0;

    // R9: disable mid-transfer
    @(negedge clk);
    reload = RW'(5); req_pulses = CW'(9); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R9 released on disable", int'(scl_drive_low), 0);
    start = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (scl_drive_low || done || phase_tick) seen++;
      end
      start = 1'b0;
      chk(seen == 0, "R9 start ignored while disabled", seen, 0);
      enable = 1'b1;
      seen = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (done || scl_drive_low) seen++;
      end
      chk(seen == 0, "R9 aborted transfer stays dropped", seen, 0);
    end

    // R1: reset during a transfer
    @(negedge clk);
    reload = RW'(4); req_pulses = CW'(6); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (23) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 1'b0, "R1 reset aborts drive", int'(scl_drive_low), 0);
    chk(done == 1'b0, "R1 reset no done", int'(done), 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(scl_drive_low == 1'b0 && done == 1'b0, "R1 idle after reset",
        int'(scl_drive_low), 0);

    // Block still usable afterwards
    do_xfer(1, 3, 1'b0);
    finish_run();
  end

endmodule